// File: doc/BRIEF.md
# Memory region access checker

The checker stores a small table of region descriptors and judges every bus access against it. Each descriptor names a naturally aligned, power-of-two address window, an eight-part sub-region disable mask, a three-bit permission code per domain, a lock field and a valid flag. An access presents an address, a domain number and a read/write flag. One cycle later the checker reports whether the access is allowed.

Descriptors are loaded through a plain write port. A write selects a descriptor, one of its four words and a 32-bit value. Word 0 is the base address. Word 1 holds the size code in bits [4:0] and the sub-region mask in bits [15:8]. Word 2 packs the permission codes of domains 0 to 7, with domain d in bits [3d+2:3d]. Word 3 packs domains 8 to 15 the same way in bits [23:0], with domain d in bits [3(d-8)+2:3(d-8)]. Word 3 also holds the lock field in bits [30:29] and the valid flag in bit 31. Permission bit 0 grants reads, bit 1 grants writes and bit 2 has no effect.

Top module: `mem_region_guard`

## Requirements
- R1: Reset clears every descriptor: not valid, unlocked, all permission codes zero. Every access after reset is denied until descriptors are written.
- R2: chk_valid rises exactly one cycle after a cycle with acc_valid high. chk_allow is never high while chk_valid is low.
- R3: A descriptor with size code SZ covers the 2^(SZ+1) bytes starting at its base. Addresses just below or just above that window do not match. SZ=31 covers the whole 32-bit space.
- R4: A size code below 4 (a region under 32 bytes) never matches any address.
- R5: A base address whose low SZ+1 bits are not all zero makes the descriptor match nothing.
- R6: In a permission code, bit 0 allows reads and bit 1 allows writes. Bit 2 grants nothing, and the code 0 denies both.
- R7: The permission code of domain d is taken from word 2 bits [3d+2:3d] when d<8, and from word 3 bits [3(d-8)+2:3(d-8)] when d>=8.
- R8: The sub-region mask splits the region into eight equal parts, numbered from the base upward. Mask bit k set makes addresses in part k fail to match.
- R9: A non-zero sub-region mask on a region smaller than 256 bytes (SZ<7) makes the descriptor match nothing.
- R10: A descriptor whose valid flag (word 3 bit 31) is clear matches nothing.
- R11: A write to word 3 with a non-zero lock field (bits [30:29]) takes effect. After it, every write to that descriptor is ignored until reset.
- R12: An access is allowed when any valid, legal, matching descriptor grants its type to the requesting domain. Otherwise the access is denied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_sel | input | SEL_W | Descriptor index |
| cfg_word | input | 2 | Word number within the descriptor |
| cfg_wdata | input | 32 | Word value |
| acc_valid | input | 1 | Access to be checked this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_dom | input | DOM_W | Requesting domain |
| acc_write | input | 1 | 1 for write, 0 for read |
| chk_valid | output | 1 | Verdict present, one cycle after acc_valid |
| chk_allow | output | 1 | Access allowed |

## Verification
The assertions assume that acc_dom stays below the domain count. They also assume that the configuration inputs are stable around the rising edge, because they judge descriptor state by whether a write strobe was present. The stimulus uses domains 0 to 15 only. It changes every input on the falling edge. It loads each descriptor word by word before probing it, and it rewrites fields between probes so that the size, mask, policy and valid cases are each probed with one field changed at a time. The lock case runs last and ends in a reset, so no locked descriptor affects the other cases.

// File: rtl/mem_region_guard.sv
module mem_region_guard #(
  parameter int NUM_DESC = 4,
  parameter int NUM_DOM  = 16,
  parameter int ADDR_W   = 32,
  localparam int SEL_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int POL_W   = 3 * NUM_DOM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_word,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DOM_W-1:0]  acc_dom,
  input  logic              acc_write,
  output logic              chk_valid,
  output logic              chk_allow
);

  logic [ADDR_W-1:0] base_q [NUM_DESC];
  logic [4:0]        sz_q   [NUM_DESC];
  logic [7:0]        srd_q  [NUM_DESC];
  logic [POL_W-1:0]  pol_q  [NUM_DESC];
  logic [1:0]        lock_q [NUM_DESC];
  logic [NUM_DESC-1:0] vld_q;
  logic [NUM_DESC-1:0] hit;
  logic dom_ok;

  assign dom_ok = (32'(acc_dom) < NUM_DOM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        base_q[i] <= '0;
        sz_q[i]   <= '0;
        srd_q[i]  <= '0;
        pol_q[i]  <= '0;
        lock_q[i] <= '0;
        vld_q[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (cfg_we && cfg_sel == SEL_W'(i) && lock_q[i] == 2'b00) begin
          case (cfg_word)
            2'd0: base_q[i] <= cfg_wdata[ADDR_W-1:0];
            2'd1: begin
              sz_q[i]  <= cfg_wdata[4:0];
              srd_q[i] <= cfg_wdata[15:8];
            end
            2'd3: begin
              lock_q[i] <= cfg_wdata[30:29];
              vld_q[i]  <= cfg_wdata[31];
            end
            default: ;
          endcase
          for (int d = 0; d < NUM_DOM; d++) begin
            if ((d < 8 && cfg_word == 2'd2) || (d >= 8 && cfg_word == 2'd3))
              pol_q[i][3*d +: 3] <= cfg_wdata[3*(d%8) +: 3];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic [63:0] lowm, a64, b64, offs;
    logic [2:0]  part, pol;
    logic        legal, inwin;

    assign lowm  = (64'd1 << (sz_q[i] + 6'd1)) - 64'd1;
    assign a64   = 64'(acc_addr);
    assign b64   = 64'(base_q[i]);
    assign offs  = a64 & lowm;
    assign part  = 3'(offs >> (sz_q[i] - 5'd2));
    assign pol   = pol_q[i][3*acc_dom +: 3];
    assign legal = (sz_q[i] >= 5'd4) && ((b64 & lowm) == 64'd0)
                   && !((srd_q[i] != 8'd0) && (sz_q[i] < 5'd7));
    assign inwin = ((a64 & ~lowm) == (b64 & ~lowm));
    assign hit[i] = vld_q[i] && legal && inwin && !srd_q[i][part]
                    && (acc_write ? pol[1] : pol[0]) && dom_ok;

    a_r11_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[i] != 2'b00) |=> ($stable(base_q[i]) && $stable(sz_q[i]) && $stable(srd_q[i])
                                && $stable(pol_q[i]) && $stable(vld_q[i])));

    a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(vld_q[i]) && $stable(pol_q[i]) && $stable(lock_q[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid <= 1'b0;
      chk_allow <= 1'b0;
    end else begin
      chk_valid <= acc_valid;
      chk_allow <= acc_valid && dom_ok && (|hit);
    end
  end

  a_r2_allow_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> chk_valid);

  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> chk_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!chk_valid && !chk_allow));

  a_r10_none_valid_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && vld_q == '0) |=> !chk_allow);

  a_r1_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> (vld_q == '0 && !chk_allow));

endmodule

// File: tb/sim_mem_region_guard.sv
`timescale 1ns/1ps
module sim_mem_region_guard;
  localparam int ND = 4;
  localparam int NDOM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0, cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0] acc_dom = '0;
  logic chk_valid, chk_allow;

  int checks = 0, errors = 0;
  string tag = "R1", exp_tag = "R1";

  mem_region_guard #(.NUM_DESC(ND), .NUM_DOM(NDOM), .ADDR_W(32)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_word, .cfg_wdata,
    .acc_valid, .acc_addr, .acc_dom, .acc_write, .chk_valid, .chk_allow);

  always #4 clk = ~clk;

  // behavioural reference
  longint m_base[ND]; int m_sz[ND]; int m_srd[ND]; int m_lock[ND]; bit m_vld[ND];
  int m_pol[ND][NDOM];
  bit exp_v = 0, exp_a = 0;

  function automatic bit ref_allow(longint addr, int dom, bit wr);
    bit any = 0;
    for (int i = 0; i < ND; i++) begin
      longint size, part_sz, off;
      int p;
      if (!m_vld[i] || m_sz[i] < 4) continue;
      size = longint'(1) << (m_sz[i] + 1);
      if (m_base[i] % size != 0) continue;
      if (m_srd[i] != 0 && size < 256) continue;
      if (addr < m_base[i] || addr >= m_base[i] + size) continue;
      off = addr - m_base[i];
      part_sz = size / 8;
      if ((m_srd[i] >> (off / part_sz)) & 1) continue;
      p = m_pol[i][dom];
      if (wr ? ((p >> 1) & 1) : (p & 1)) any = 1;
    end
    return any;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ND; i++) begin
        m_base[i] = 0; m_sz[i] = 0; m_srd[i] = 0; m_lock[i] = 0; m_vld[i] = 0;
        for (int d = 0; d < NDOM; d++) m_pol[i][d] = 0;
      end
      exp_v = 0; exp_a = 0;
    end else begin
      exp_v = acc_valid;
      exp_a = acc_valid && ref_allow(longint'(acc_addr), int'(acc_dom), acc_write);
      exp_tag = tag;
      if (cfg_we && m_lock[cfg_sel] == 0) begin
        case (cfg_word)
          2'd0: m_base[cfg_sel] = longint'(cfg_wdata);
          2'd1: begin m_sz[cfg_sel] = int'(cfg_wdata[4:0]); m_srd[cfg_sel] = int'(cfg_wdata[15:8]); end
          2'd2: for (int d = 0; d < 8; d++) m_pol[cfg_sel][d] = int'(cfg_wdata[3*d +: 3]);
          default: begin
            for (int d = 8; d < 16; d++) m_pol[cfg_sel][d] = int'(cfg_wdata[3*(d-8) +: 3]);
            m_lock[cfg_sel] = int'(cfg_wdata[30:29]);
            m_vld[cfg_sel] = cfg_wdata[31];
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (chk_valid !== exp_v || chk_allow !== exp_a) begin
      errors++;
      $display("FAIL %s model compare: valid/allow %b%b expected %b%b", exp_tag,
               chk_valid, chk_allow, exp_v, exp_a);
    end
  end

  task automatic wr(input int sel, input int word, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_word = 2'(word); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input string t, input logic [31:0] a, input int dom, input bit w, input bit e);
    @(negedge clk);
    tag = t; acc_valid = 1'b1; acc_addr = a; acc_dom = 4'(dom); acc_write = w;
    @(negedge clk);
    checks++;
    if (chk_valid !== 1'b1 || chk_allow !== e) begin
      errors++;
      $display("FAIL %s addr %h dom %0d wr %0d: valid/allow %b%b expected 1%b",
               t, a, dom, w, chk_valid, chk_allow, e);
    end
    acc_valid = 1'b0;
  endtask

  task automatic idle_check(input string t);
    @(negedge clk);
    checks++;
    if (chk_valid !== 1'b0 || chk_allow !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: valid/allow %b%b expected 00", t, chk_valid, chk_allow);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    acc("R1", 32'h0000_1000, 0, 0, 0);
    idle_check("R2");

    // desc0: base 0x1000, 256 bytes, dom0 RW, dom7 R, dom9 W
    wr(0, 0, 32'h0000_1000);
    wr(0, 1, 32'd7);
    wr(0, 2, 32'd3 | (32'd1 << 21));
    wr(0, 3, 32'h8000_0000 | (32'd2 << 3));
    acc("R3", 32'h0000_1000, 0, 0, 1);
    acc("R3", 32'h0000_10FF, 0, 1, 1);
    acc("R3", 32'h0000_1100, 0, 0, 0);
    acc("R3", 32'h0000_0FFF, 0, 0, 0);
    acc("R7", 32'h0000_1010, 7, 0, 1);
    acc("R7", 32'h0000_1010, 7, 1, 0);
    acc("R7", 32'h0000_1010, 9, 1, 1);
    acc("R7", 32'h0000_1010, 9, 0, 0);
    acc("R6", 32'h0000_1010, 1, 0, 0);
    idle_check("R2");

    wr(0, 2, 32'd4);
    acc("R6", 32'h0000_1010, 0, 0, 0);
    acc("R6", 32'h0000_1010, 0, 1, 0);
    wr(0, 2, 32'd2);
    acc("R6", 32'h0000_1010, 0, 1, 1);
    acc("R6", 32'h0000_1010, 0, 0, 0);
    wr(0, 2, 32'd3);

    wr(0, 3, 32'h0000_0000 | (32'd2 << 3));
    acc("R10", 32'h0000_1010, 9, 1, 0);
    acc("R10", 32'h0000_1010, 0, 0, 0);
    wr(0, 3, 32'h8000_0000 | (32'd2 << 3));
    acc("R10", 32'h0000_1010, 0, 0, 1);

    wr(0, 1, 32'd7 | (32'd1 << 10));
    acc("R8", 32'h0000_1040, 0, 0, 0);
    acc("R8", 32'h0000_105F, 0, 1, 0);
    acc("R8", 32'h0000_1060, 0, 0, 1);
    acc("R8", 32'h0000_103F, 0, 0, 1);

    wr(0, 1, 32'd6 | (32'd1 << 8));
    acc("R9", 32'h0000_1070, 0, 0, 0);
    wr(0, 1, 32'd6);
    acc("R9", 32'h0000_1070, 0, 0, 1);

    wr(0, 1, 32'd3);
    acc("R4", 32'h0000_1000, 0, 0, 0);
    wr(0, 1, 32'd4);
    acc("R4", 32'h0000_101F, 0, 0, 1);
    acc("R3", 32'h0000_1020, 0, 0, 0);

    wr(0, 0, 32'h0000_1010);
    acc("R5", 32'h0000_1010, 0, 0, 0);
    wr(0, 0, 32'h0000_1020);
    acc("R5", 32'h0000_1020, 0, 0, 1);

    wr(0, 0, 32'h0000_0000);
    wr(0, 1, 32'd31);
    acc("R3", 32'hFFFF_FFF0, 0, 1, 1);
    acc("R3", 32'h0000_0000, 0, 0, 1);
    wr(0, 3, 32'd0);

    // overlapping descriptors, domain 3
    wr(2, 0, 32'h0000_8000);
    wr(2, 1, 32'd11);
    wr(2, 2, 32'd1 << 9);
    wr(2, 3, 32'h8000_0000);
    wr(3, 0, 32'h0000_8000);
    wr(3, 1, 32'd7);
    wr(3, 2, 32'd2 << 9);
    wr(3, 3, 32'h8000_0000);
    acc("R12", 32'h0000_8010, 3, 1, 1);
    acc("R12", 32'h0000_8200, 3, 1, 0);
    acc("R12", 32'h0000_8200, 3, 0, 1);
    acc("R12", 32'h0000_8010, 3, 0, 1);
    acc("R12", 32'h0000_9000, 3, 0, 0);

    // lock
    wr(1, 0, 32'h0000_2000);
    wr(1, 1, 32'd7);
    wr(1, 2, 32'd3);
    wr(1, 3, 32'h8000_0000 | (32'd1 << 29));
    acc("R11", 32'h0000_2000, 0, 0, 1);
    wr(1, 2, 32'd0);
    acc("R11", 32'h0000_2000, 0, 0, 1);
    wr(1, 3, 32'd0);
    acc("R11", 32'h0000_2004, 0, 1, 1);
    wr(1, 0, 32'h0000_4000);
    acc("R11", 32'h0000_2080, 0, 0, 1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc("R1", 32'h0000_2000, 0, 0, 0);
    acc("R1", 32'h0000_8010, 3, 1, 0);
    wr(1, 2, 32'd3);
    wr(1, 3, 32'h8000_0000);
    acc("R11", 32'h0000_0010, 0, 0, 0);
    idle_check("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule